// File: doc/BRIEF.md
# Latched Bidirectional Port Group

This block is an eight-channel bidirectional I/O port. The channels form two groups of four, and each group has its own direction bit. The host writes an output register and a small control word: the two direction bits and a mode bit. A read returns the channel data. On the pad side the block drives a data vector and a per-channel driver enable, and it samples the pad levels. Electrical buffering is left to the pad ring.

With the mode bit clear, the port is a plain I/O port. A read returns the live pin level on input channels and the output register on output channels. Two external strobes have no effect in this mode. With the mode bit set, the port captures the input levels into a holding register on every falling edge of a capture strobe. Reads then return the held value on input channels. Output drivers are enabled only while an active-low drive strobe is held low. Both strobes pass through a two-flop synchronizer. A status LED output is lit while the mode bit is clear.

Top module: `latched_port_group`

## Requirements
- R1: During and after reset every channel is an input (`pad_oe` all zero), the mode bit reads 0, both direction bits read 0, `led_on` is 1, and the output register and holding register are 0.
- R2: Direction bit 0 controls channels 3..0 and direction bit 1 controls channels 7..4. A 0 makes the group inputs and a 1 makes it outputs. In direct mode `pad_oe` of a channel equals its group's direction bit, and `pad_out` always carries the output register.
- R3: In direct mode a read returns `pad_in` for input channels and the output register for output channels, bit for bit with no inversion, in the same cycle.
- R4: A write to the output register is taken whatever the direction. When a group is later switched to output, it drives the value already written.
- R5: In latch mode, each high-to-low transition of `latch_strb` stores `pad_in` into the holding register. The new value shows on reads of input channels after the third rising clock edge that follows the strobe going low.
- R6: In latch mode a read returns the holding register for input channels and the output register for output channels.
- R7: In latch mode an output channel is driven (`pad_oe` = 1) only while `outen_n` is low. The change follows `outen_n` after the second rising edge. Input channels are never driven in any mode.
- R8: In direct mode both strobes are ignored. `outen_n` does not change `pad_oe`, and `latch_strb` edges leave the holding register untouched, which is visible after a later switch to latch mode.
- R9: `led_on` is 1 while the mode bit is 0 and 0 while it is 1.
- R10: A strobe held low captures once. Later changes on `pad_in` are not stored until the strobe has risen and fallen again.
- R11: A control write sets the direction and mode readbacks after one rising edge. A data write updates the output register after one rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released in step with `clk` |
| host_wr_data | input | 1 | Write strobe for the output register |
| host_data_i | input | 8 | Output register write value |
| host_wr_cfg | input | 1 | Write strobe for direction and mode bits |
| host_dir_i | input | 2 | Direction bits, bit g for group g (1 = outputs) |
| host_mode_i | input | 1 | Mode bit (1 = latch mode) |
| host_rd_data | output | 8 | Channel data read value |
| host_dir_o | output | 2 | Direction bits readback |
| host_mode_o | output | 1 | Mode bit readback |
| pad_in | input | 8 | Pin levels from the pads |
| pad_out | output | 8 | Output data to the pads |
| pad_oe | output | 8 | Per-channel pad driver enable |
| latch_strb | input | 1 | Capture strobe, acts on its falling edge in latch mode |
| outen_n | input | 1 | Active-low driver gate in latch mode |
| led_on | output | 1 | Status LED, lit in direct mode |

## Verification
Results fall due at different times, so the bench paces each stimulus against the clock edges the result needs. Direct-mode reads follow `pad_in` with no clock at all. Host writes act after one edge. A drive-strobe change reaches `pad_oe` after two edges. A capture strobe's fall reaches the read data after three edges. A behavioural reference model keeps the recent strobe samples in queues and predicts every output on each falling clock edge. Directed checks also sample one cycle before and at the edge each result is due, so an early or late capture or gate shows up as a mismatch.

// File: rtl/lpg_pkg.sv
package lpg_pkg;
  typedef enum logic {
    MODE_DIRECT  = 1'b0,
    MODE_LATCHED = 1'b1
  } port_mode_e;

  localparam int unsigned LPG_GROUPS_DEF  = 2;
  localparam int unsigned LPG_GROUP_W_DEF = 4;
  localparam int unsigned LPG_SYNC_DEF    = 2;
endpackage

// File: rtl/lpg_strobe_sync.sv
module lpg_strobe_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic        IDLE   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_i,
  output logic sync_o
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = (sh_q << 1) | STAGES'(strobe_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= {STAGES{IDLE}};
    else        sh_q <= sh_d;
  end

  assign sync_o = sh_q[STAGES-1];
endmodule

// File: rtl/lpg_hold_capture.sv
module lpg_hold_capture #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         arm_i,
  input  logic         strb_sync_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] hold_o
);
  logic         prev_q;
  logic         fall;
  logic         load;
  logic [W-1:0] hold_q;

  always_comb begin
    fall = prev_q & ~strb_sync_i;
    load = arm_i & fall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= strb_sync_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hold_q <= '0;
    else if (load) hold_q <= din_i;
  end

  assign hold_o = hold_q;
endmodule

// File: rtl/lpg_cfg_regs.sv
module lpg_cfg_regs
  import lpg_pkg::*;
#(
  parameter int unsigned GROUPS = LPG_GROUPS_DEF,
  parameter int unsigned CH     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_data_i,
  input  logic [CH-1:0]     data_i,
  input  logic              wr_cfg_i,
  input  logic [GROUPS-1:0] dir_i,
  input  logic              mode_i,
  output logic [CH-1:0]     out_o,
  output logic [GROUPS-1:0] dir_o,
  output port_mode_e        mode_o
);
  logic [CH-1:0]     out_q;
  logic [GROUPS-1:0] dir_q;
  port_mode_e        mode_q;
  port_mode_e        mode_d;

  always_comb begin
    mode_d = mode_i ? MODE_LATCHED : MODE_DIRECT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         out_q <= '0;
    else if (wr_data_i) out_q <= data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      mode_q <= MODE_DIRECT;
    end else if (wr_cfg_i) begin
      dir_q  <= dir_i;
      mode_q <= mode_d;
    end
  end

  assign out_o  = out_q;
  assign dir_o  = dir_q;
  assign mode_o = mode_q;
endmodule

// File: rtl/latched_port_group.sv
module latched_port_group
  import lpg_pkg::*;
#(
  parameter int unsigned GROUPS  = LPG_GROUPS_DEF,
  parameter int unsigned GROUP_W = LPG_GROUP_W_DEF,
  parameter int unsigned SYNC    = LPG_SYNC_DEF,
  localparam int unsigned CH     = GROUPS * GROUP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_data,
  input  logic [CH-1:0]     host_data_i,
  input  logic              host_wr_cfg,
  input  logic [GROUPS-1:0] host_dir_i,
  input  logic              host_mode_i,
  output logic [CH-1:0]     host_rd_data,
  output logic [GROUPS-1:0] host_dir_o,
  output logic              host_mode_o,
  input  logic [CH-1:0]     pad_in,
  output logic [CH-1:0]     pad_out,
  output logic [CH-1:0]     pad_oe,
  input  logic              latch_strb,
  input  logic              outen_n,
  output logic              led_on
);
  logic [CH-1:0]     out_q;
  logic [GROUPS-1:0] dir_q;
  port_mode_e        mode_q;
  logic [CH-1:0]     hold_q;
  logic [CH-1:0]     dir_exp;
  logic              latch_sync;
  logic              outen_sync;
  logic              latched;
  logic              drive_ok;
  logic [CH-1:0]     in_src;

  lpg_cfg_regs #(.GROUPS(GROUPS), .CH(CH)) cfg_i (
    .clk(clk), .rst_n(rst_n),
    .wr_data_i(host_wr_data), .data_i(host_data_i),
    .wr_cfg_i(host_wr_cfg), .dir_i(host_dir_i), .mode_i(host_mode_i),
    .out_o(out_q), .dir_o(dir_q), .mode_o(mode_q)
  );

  lpg_strobe_sync #(.STAGES(SYNC), .IDLE(1'b1)) latch_sync_i (
    .clk(clk), .rst_n(rst_n), .strobe_i(latch_strb), .sync_o(latch_sync)
  );

  lpg_strobe_sync #(.STAGES(SYNC), .IDLE(1'b1)) outen_sync_i (
    .clk(clk), .rst_n(rst_n), .strobe_i(outen_n), .sync_o(outen_sync)
  );

  assign latched = (mode_q == MODE_LATCHED);

  lpg_hold_capture #(.W(CH)) hold_i (
    .clk(clk), .rst_n(rst_n), .arm_i(latched), .strb_sync_i(latch_sync),
    .din_i(pad_in), .hold_o(hold_q)
  );

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    assign dir_exp[g*GROUP_W +: GROUP_W] = {GROUP_W{dir_q[g]}};
  end

  always_comb begin
    in_src       = latched ? hold_q : pad_in;
    host_rd_data = (out_q & dir_exp) | (in_src & ~dir_exp);
    drive_ok     = ~latched | ~outen_sync;
    pad_oe       = dir_exp & {CH{drive_ok}};
  end

  assign pad_out     = out_q;
  assign host_dir_o  = dir_q;
  assign host_mode_o = latched;
  assign led_on      = ~latched;
endmodule

// File: rtl/lpg_checker.sv
module lpg_checker #(
  parameter int unsigned GROUPS  = 2,
  parameter int unsigned GROUP_W = 4,
  parameter int unsigned CH      = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_mode_o,
  input logic [GROUPS-1:0] host_dir_o,
  input logic [CH-1:0]     host_rd_data,
  input logic [CH-1:0]     pad_oe,
  input logic              led_on,
  input logic              outen_n,
  input logic [CH-1:0]     out_q,
  input logic [CH-1:0]     hold_q
);
  logic [CH-1:0] dir_exp;

  for (genvar g = 0; g < GROUPS; g++) begin : g_exp
    assign dir_exp[g*GROUP_W +: GROUP_W] = {GROUP_W{host_dir_o[g]}};
  end

  AST_OE_FOLLOWS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    !host_mode_o |-> (pad_oe == dir_exp)); // R2
  AST_INPUTS_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> ((pad_oe & ~dir_exp) == '0)); // R7
  AST_GATE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (host_mode_o && $past(outen_n, 2)) |-> (pad_oe == '0)); // R7
  AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(host_mode_o) |-> $stable(hold_q)); // R8
  AST_LED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_mode_o) |-> !led_on); // R9
  AST_LED_ON: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(host_mode_o) |-> led_on); // R9
  AST_OUT_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> ((host_rd_data & dir_exp) == (out_q & dir_exp))); // R6
endmodule

bind latched_port_group lpg_checker #(.GROUPS(GROUPS), .GROUP_W(GROUP_W), .CH(CH)) chk_i (
  .clk(clk), .rst_n(rst_n), .host_mode_o(host_mode_o), .host_dir_o(host_dir_o),
  .host_rd_data(host_rd_data), .pad_oe(pad_oe), .led_on(led_on), .outen_n(outen_n),
  .out_q(out_q), .hold_q(hold_q)
);

// File: tb/latched_port_group_tb.sv
module latched_port_group_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr_data = 1'b0;
  logic [7:0] host_data_i = '0;
  logic       host_wr_cfg = 1'b0;
  logic [1:0] host_dir_i = '0;
  logic       host_mode_i = 1'b0;
  logic [7:0] host_rd_data;
  logic [1:0] host_dir_o;
  logic       host_mode_o;
  logic [7:0] pad_in = '0;
  logic [7:0] pad_out;
  logic [7:0] pad_oe;
  logic       latch_strb = 1'b1;
  logic       outen_n = 1'b1;
  logic       led_on;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  latched_port_group dut_i (
    .clk(clk), .rst_n(rst_n),
    .host_wr_data(host_wr_data), .host_data_i(host_data_i),
    .host_wr_cfg(host_wr_cfg), .host_dir_i(host_dir_i), .host_mode_i(host_mode_i),
    .host_rd_data(host_rd_data), .host_dir_o(host_dir_o), .host_mode_o(host_mode_o),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .latch_strb(latch_strb), .outen_n(outen_n), .led_on(led_on)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [1:0] m_dir;
  logic       m_mode;
  logic [7:0] m_out;
  logic [7:0] m_hold;
  bit         lq[$];
  bit         oq[$];

  function automatic logic [7:0] m_expand(input logic [1:0] d);
    return {{4{d[1]}}, {4{d[0]}}};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dir = '0; m_mode = 1'b0; m_out = '0; m_hold = '0;
      lq = '{1, 1, 1, 1};
      oq = '{1, 1, 1, 1};
    end else begin
      if (m_mode && lq[lq.size()-2] == 1'b0 && lq[lq.size()-3] == 1'b1) m_hold = pad_in;
      if (host_wr_cfg)  begin m_dir = host_dir_i; m_mode = host_mode_i; end
      if (host_wr_data) m_out = host_data_i;
      lq.push_back(latch_strb); void'(lq.pop_front());
      oq.push_back(outen_n);    void'(oq.pop_front());
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      logic [7:0] de;
      logic [7:0] eoe;
      de  = m_expand(m_dir);
      eoe = (m_mode && oq[oq.size()-2] == 1'b1) ? 8'h00 : de;
      chk("model R2 R7 R8 pad_oe", pad_oe, eoe);
      chk("model R3 R5 R6 rd_data", host_rd_data, (m_out & de) | ((m_mode ? m_hold : pad_in) & ~de));
      chk("model R4 pad_out", pad_out, m_out);
      chk("model R9 led_on", {7'b0, led_on}, {7'b0, ~m_mode});
      chk("model R11 readback", {5'b0, host_mode_o, host_dir_o}, {5'b0, m_mode, m_dir});
    end
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic wr_cfg(input logic [1:0] d, input logic m);
    host_dir_i = d; host_mode_i = m; host_wr_cfg = 1'b1;
    tick(); host_wr_cfg = 1'b0;
  endtask

  task automatic wr_out(input logic [7:0] v);
    host_data_i = v; host_wr_data = 1'b1;
    tick(); host_wr_data = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    pad_in = 8'h5A;
    tick(3);
    chk("R1 oe in reset", pad_oe, 8'h00);
    chk("R1 led in reset", {7'b0, led_on}, 8'h01);
    rst_n = 1'b1;
    tick();
    chk("R1 oe after reset", pad_oe, 8'h00);
    chk("R1 mode/dir after reset", {5'b0, host_mode_o, host_dir_o}, 8'h00);
    chk("R1 out reg after reset", pad_out, 8'h00);

    // direct mode reads follow pins
    pad_in = 8'hC3; #1;
    chk("R3 live input read", host_rd_data, 8'hC3);
    pad_in = 8'h3C; #1;
    chk("R3 live input read 2", host_rd_data, 8'h3C);

    // write output while input, then switch direction
    wr_out(8'hA5);
    chk("R4 out reg taken while input", pad_out, 8'hA5);
    chk("R4 no drive while input", pad_oe, 8'h00);
    wr_cfg(2'b01, 1'b0);
    chk("R2 low group output", pad_oe, 8'h0F);
    chk("R3 mixed read", host_rd_data, 8'h35);
    wr_cfg(2'b10, 1'b0);
    chk("R2 high group output", pad_oe, 8'hF0);
    chk("R3 mixed read high", host_rd_data, 8'hAC);
    wr_cfg(2'b11, 1'b0);
    chk("R11 dir readback", {6'b0, host_dir_o}, 8'h03);

    // strobes ignored in direct mode
    outen_n = 1'b1; tick(3);
    chk("R8 outen ignored", pad_oe, 8'hFF);
    pad_in = 8'h99;
    latch_strb = 1'b0; tick(4);
    latch_strb = 1'b1; tick(3);
    latch_strb = 1'b0; tick(4);
    latch_strb = 1'b1; tick(3);

    // enter latch mode, all inputs
    wr_cfg(2'b00, 1'b1);
    chk("R9 led off", {7'b0, led_on}, 8'h00);
    chk("R11 mode readback", {7'b0, host_mode_o}, 8'h01);
    chk("R8 hold untouched by direct-mode strobes", host_rd_data, 8'h00);

    // capture
    pad_in = 8'h3C;
    latch_strb = 1'b0;
    tick(2);
    chk("R5 not yet captured", host_rd_data, 8'h00);
    tick();
    chk("R5 captured on third edge", host_rd_data, 8'h3C);
    pad_in = 8'hFF; tick(5);
    chk("R10 one capture per low", host_rd_data, 8'h3C);
    latch_strb = 1'b1; tick(3);
    pad_in = 8'h81; latch_strb = 1'b0; tick(3);
    chk("R5 second capture", host_rd_data, 8'h81);
    latch_strb = 1'b1;
    pad_in = 8'h00; tick(2);

    // latch mode: output group reads out reg, drive gated
    wr_cfg(2'b01, 1'b1);
    chk("R6 mixed latch read", host_rd_data, 8'h85);
    chk("R7 gated off", pad_oe, 8'h00);
    outen_n = 1'b0; tick();
    chk("R7 gate not yet open", pad_oe, 8'h00);
    tick();
    chk("R7 gate open after two edges", pad_oe, 8'h0F);
    outen_n = 1'b1; tick(2);
    chk("R7 gate closed again", pad_oe, 8'h00);

    // back to direct mode
    wr_cfg(2'b01, 1'b0);
    chk("R9 led on again", {7'b0, led_on}, 8'h01);
    chk("R2 direct drive restored", pad_oe, 8'h0F);
    pad_in = 8'hE7; #1;
    chk("R3 live read restored", host_rd_data, 8'hE5);
    tick(3);
    finish_run();
  end
endmodule